// File: doc/BRIEF.md
# Marker-Terminated Serial Frame Transmitter

This block sends one asynchronous character on a single serial line. Each frame is a low start bit, a byte of data sent least significant bit first, and a high stop bit. Bit timing comes from an external free-running divide-by-16 counter. The block sees that counter only as a one-clock `tick` pulse at each rollover, so every bit edge on the line falls on a rollover and never on the write strobe.

A byte write loads the data into a shift register that is one bit wider than the data. The extra bit is a 1 placed above the most significant data bit. As the register shifts right it fills with zeros, so the end of the frame shows up as a fixed pattern: the marker sits directly above the bit on the output and everything higher is zero. No bit counter is needed. On the rollover that finds this pattern the block makes a last shift, leaves the transmitting phase and sets a sticky done flag. That flag stays set until a clear pulse arrives.

Top module: `mft_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, `txd` is 1 and `done` is 0.
- R2: When no frame is pending or in progress, `txd` stays at 1.
- R3: A frame drives `txd` to 0 for one bit time (one tick interval), then drives data bits 0 to DATA_W-1 one bit time each, least significant first, then drives 1 for the stop bit.
- R4: The start bit begins on the first `tick` after the clock edge that accepts the write. A `tick` in the same cycle as the write does not start the frame, and the line stays 1 until the start tick.
- R5: `done` rises on the clock edge of the (DATA_W+2)-th `tick` counted from the write, which is the 10th for 8-bit data, and not on any earlier edge.
- R6: A byte write that arrives while a frame is pending or being sent has no effect: the frame in flight keeps its original bits.
- R7: Once set, `done` stays 1 until `done_clr` is pulsed. The clear drops it to 0 on the next edge.
- R8: When `done_clr` is asserted in the same cycle as the tick that completes a frame, `done` ends up set.
- R9: After `done` rises, the next byte write is accepted, so frames can follow each other with no other action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at each rollover of the divide-by-16 bit-rate counter |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to send, captured with `wr_stb` |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line, idle high |
| done | output | 1 | Sticky transmit-complete flag |

## Verification
Two events can meet in one cycle: the completing rollover, which sets `done`, and a `done_clr` pulse. The bench also lines up a write with a rollover, and a second write with a frame in flight. For a subset of bytes the bench raises `done_clr` exactly on the cycle that carries the completing tick and expects `done` to be 1 afterwards. It also sweeps the write's phase against the rollover across all sixteen offsets. In every sweep the start bit must begin on the rollover strictly after the write, and a write made during the frame must leave every sampled line bit unchanged.

// File: rtl/mft_pkg.sv
package mft_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PEND  = 2'd1,
      PH_START = 2'd2,
      PH_DATA  = 2'd3
   } tx_phase_e;

   localparam int MFT_MIN_DATA_W = 2;

endpackage

// File: rtl/mft_shifter.sv
module mft_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   output logic              sbit,
   output logic              last
);
   localparam int SR_W = DATA_W + 1;

   logic [SR_W-1:0] sr_q;
   logic [SR_W-1:0] seed;

   assign seed = {1'b1, load_data};

   if (DATA_W < mft_pkg::MFT_MIN_DATA_W) begin : g_bad_width
      $error("mft_shifter: DATA_W must be at least 2");
   end

   for (genvar i = 0; i < SR_W; i++) begin : g_cell
      logic up;
      logic q;
      if (i == SR_W - 1) begin : g_top
         assign up = 1'b0;
      end else begin : g_mid
         assign up = sr_q[i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= 1'b0;
         else if (load)  q <= seed[i];
         else if (shift) q <= up;
      end
      assign sr_q[i] = q;
   end

   assign sbit = sr_q[0];
   assign last = sr_q[1] && (sr_q[SR_W-1:2] == '0);

endmodule

// File: rtl/mft_phase_ctrl.sv
module mft_phase_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic tick,
   input  logic last,
   output logic load,
   output logic shift,
   output logic fin,
   output logic send,
   output logic data_ph,
   output logic pend
);
   import mft_pkg::*;

   tx_phase_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PH_IDLE:  if (wr_stb) st_d = PH_PEND;
         PH_PEND:  if (tick)   st_d = PH_START;
         PH_START: if (tick)   st_d = PH_DATA;
         PH_DATA:  if (tick && last) st_d = PH_IDLE;
         default:  st_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PH_IDLE;
      else        st_q <= st_d;
   end

   assign load    = wr_stb && (st_q == PH_IDLE);
   assign shift   = tick && (st_q == PH_DATA);
   assign fin     = shift && last;
   assign send    = (st_q == PH_START) || (st_q == PH_DATA);
   assign data_ph = (st_q == PH_DATA);
   assign pend    = (st_q == PH_PEND);

endmodule

// File: rtl/mft_done_flag.sv
module mft_done_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/mft_frame_tx.sv
module mft_frame_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              done_clr,
   output logic              txd,
   output logic              done
);
   logic load_w, shift_w, fin_w, send_w, data_w, pend_w;
   logic sbit_w, last_w;

   mft_phase_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .tick    (tick),
      .last    (last_w),
      .load    (load_w),
      .shift   (shift_w),
      .fin     (fin_w),
      .send    (send_w),
      .data_ph (data_w),
      .pend    (pend_w)
   );

   mft_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_w),
      .load_data (wr_data),
      .shift     (shift_w),
      .sbit      (sbit_w),
      .last      (last_w)
   );

   mft_done_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (fin_w),
      .clr   (done_clr),
      .flag  (done)
   );

   // Start bit while sending outside the data phase, register output in data phase, idle high.
   assign txd = send_w ? (data_w ? sbit_w : 1'b0) : 1'b1;

endmodule

// File: rtl/mft_frame_tx_chk.sv
module mft_frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic wr_stb,
   input logic done_clr,
   input logic txd,
   input logic done,
   input logic send,
   input logic data_ph,
   input logic pend,
   input logic last,
   input logic sbit
);
   AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(send) |-> ($past(tick) && $past(pend))); // R4

   AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !send && !pend) |=> !send); // R4

   AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ph) |-> !$past(txd)); // R3

   AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(send) |-> txd); // R3

   AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(tick) && $past(data_ph) && $past(last))); // R5

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_clr) |=> done); // R7

   AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(done_clr)); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr && tick && data_ph && last) |=> done); // R8

   AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && data_ph && !tick) |=> $stable(sbit)); // R6

endmodule

bind mft_frame_tx mft_frame_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_stb   (wr_stb),
   .done_clr (done_clr),
   .txd      (txd),
   .done     (done),
   .send     (send_w),
   .data_ph  (data_w),
   .pend     (pend_w),
   .last     (last_w),
   .sbit     (sbit_w)
);

// File: tb/sim_mft_frame_tx.sv
`timescale 1ns/1ps
module sim_mft_frame_tx;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_stb = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic done_clr = 1'b0;
   logic txd, done, tick;
   logic [3:0] div_q = 4'd0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) div_q <= div_q + 4'd1;
   assign tick = (div_q == 4'd15);

   mft_frame_tx #(.DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_stb(wr_stb),
      .wr_data(wr_data), .done_clr(done_clr), .txd(txd), .done(done)
   );

   task automatic chk(input string rq, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // Wait for the next rollover; return at the negedge after it. Optionally clear on that edge.
   task automatic wait_tick(input bit clr);
      while (!tick) @(negedge clk);
      if (clr) done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
   endtask

   task automatic run_frame(input logic [DW-1:0] b, input int pre,
                            input bit twice, input bit meddle, input bit collide);
      logic exp;
      repeat (pre) @(negedge clk);
      wr_stb = 1'b1; wr_data = b;
      @(negedge clk);
      wr_stb = 1'b0; wr_data = ~b;
      chk("R4", txd, 1'b1);
      if (twice && !tick) begin
         wr_stb = 1'b1;
         @(negedge clk);
         wr_stb = 1'b0;
         chk("R6", txd, 1'b1);
      end
      for (int j = 1; j <= DW + 2; j++) begin
         wait_tick(collide && (j == DW + 2));
         repeat (7) @(negedge clk);
         if (j == 1)           exp = 1'b0;
         else if (j <= DW + 1) exp = b[j-2];
         else                  exp = 1'b1;
         chk(j == 1 ? "R4" : (meddle ? "R6" : "R3"), txd, exp);
         if (j == DW + 2) chk(collide ? "R8" : "R5", done, 1'b1);
         else             chk("R5", done, 1'b0);
         if (meddle && j == 4) begin
            wr_stb = 1'b1; wr_data = ~b;
            @(negedge clk);
            wr_stb = 1'b0;
         end
      end
      wait_tick(1'b0);
      repeat (7) @(negedge clk);
      chk("R2", txd, 1'b1);
      chk("R7", done, 1'b1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R7", done, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", txd, 1'b1);
      chk("R1", done, 1'b0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1", txd, 1'b1);
      chk("R1", done, 1'b0);
      chk("R2", txd, 1'b1);
      for (int v = 0; v < 256; v++) begin
         run_frame(v[DW-1:0], v % 16, (v % 4) == 1, (v % 3) == 2, (v % 32) == 7);
      end
      // R9: back-to-back frames with no gap beyond the flag clear
      run_frame(8'hA5, 0, 1'b0, 1'b0, 1'b0);
      run_frame(8'h5A, 0, 1'b0, 1'b0, 1'b0);
      chk("R9", txd, 1'b1);
      finish_run();
   end
endmodule